// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital control core of a LIN physical-layer transceiver. It tracks four operating modes (Reset, Sleep, Standby, Normal) and, from them, decides whether the bus transmitter may drive and what the RXD pin should do: float, hold low as a wake interrupt, or pass received bus data through.

Mode changes come from a power-good flag, an active-low sleep-control pin, and a one-cycle wake pulse from a separate bus wake detector. The sleep-control and TXD pins are asynchronous and pass through a two-flop synchronizer. Hold times on the sleep-control pin are counted in clock cycles. The count is derived from a tick rate given in cycles per microsecond and from hold times given in microseconds.

The transmitter is gated by three protection flags. Whenever the transmit path has been blocked, by mode entry, undervoltage or overtemperature, it opens again only after TXD has been seen recessive (high). A TXD pin stuck low can therefore never hold the bus dominant.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While `por_ok_i` is low, `mode_o` becomes 0 (Reset) on the next clock edge and stays there, with `rxd_sel_o` = 0 (float) and `tx_en_o` low. The sleep-control, TXD and wake inputs have no effect.
- R2: In Reset, the first clock edge with `por_ok_i` high moves the block to Sleep (`mode_o` = 1, `rxd_sel_o` = 0).
- R3: In Normal, `slp_n_i` held low for SLEEP_TICKS consecutive synchronized cycles moves the block to Sleep. This happens on the SLEEP_TICKS+2-th rising edge after the pin changes. A shorter low pulse restarts the count and causes no transition.
- R4: In Normal, `tx_en_o` goes low two edges after `slp_n_i` falls, as soon as the synchronized level is low, before the sleep timer expires.
- R5: Sleep entry depends on `slp_n_i` only. A low TXD, undervoltage or overtemperature at that time does not change its timing.
- R6: In Sleep, a high `wake_i` at a clock edge moves the block to Standby (`mode_o` = 2) with `rxd_sel_o` = 1 (force low) and `tx_en_o` low. `wake_i` has no effect in Standby or Normal.
- R7: From Sleep or Standby, `slp_n_i` held high for NORM_TICKS synchronized cycles moves the block to Normal (`mode_o` = 3, `rxd_sel_o` = 2, pass data). This happens on the NORM_TICKS+2-th edge after the pin rises. A shorter high pulse causes no transition.
- R8: On entry to Normal, `tx_en_o` stays low while TXD is low. It rises three edges after TXD rises (two synchronizer stages plus the arming register).
- R9: `uv_i` high forces `tx_en_o` low in the same cycle. After `uv_i` clears, `tx_en_o` stays low until TXD is seen high.
- R10: `tsd_i` high forces `tx_en_o` low in the same cycle. After `tsd_i` clears, `tx_en_o` stays low until TXD is seen high. Neither `uv_i` nor `tsd_i` changes the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_ok_i | input | 1 | Supply above power-on threshold (synchronous) |
| slp_n_i | input | 1 | Sleep control pin, active low, asynchronous |
| txd_i | input | 1 | Transmit data pin, asynchronous |
| wake_i | input | 1 | One-cycle remote wake pulse from bus detector |
| uv_i | input | 1 | Battery undervoltage flag (synchronous) |
| tsd_i | input | 1 | Thermal shutdown flag (synchronous) |
| tx_en_o | output | 1 | Transmitter enable |
| rxd_sel_o | output | 2 | RXD control: 0 float, 1 force low, 2 pass bus data |
| mode_o | output | 2 | Mode: 0 Reset, 1 Sleep, 2 Standby, 3 Normal |

## Verification
The bench sweeps every pulse length on the sleep-control pin from one cycle up to one short of each hold time and expects no mode change. It then holds the pin and expects the transition on exactly the edge predicted from the synchronizer depth plus the hold count. An off-by-one timer, or a timer that does not restart on a glitch, shows up as a transition one edge early or late, or as a spurious one. It also holds TXD low across Normal entry, undervoltage recovery and thermal recovery. A design that re-enables on mode entry or on flag release alone would drive the bus while TXD is dominant. Wake pulses outside Sleep and pin activity while the supply is not good are applied too; a design that leaks them would change mode.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RESET   = 2'd0,
    MODE_SLEEP   = 2'd1,
    MODE_STANDBY = 2'd2,
    MODE_NORMAL  = 2'd3
  } lin_mode_e;

  typedef enum logic [1:0] {
    RXD_FLOAT = 2'd0,
    RXD_LOW   = 2'd1,
    RXD_DATA  = 2'd2
  } rxd_sel_e;
endpackage

// File: rtl/lin_pin_sync.sv
module lin_pin_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lin_hold_timer.sv
module lin_hold_timer #(
  parameter int unsigned LIMIT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign fire_o = run_i && (cnt_q == CW'(LIMIT - 1));

  // any break in run_i restarts the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || fire_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // R3 / R7: a fire needs the condition on the previous cycle too
  if (LIMIT >= 2) begin : g_win_chk
    a_r3_hold_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |-> $past(run_i));
  end
endmodule

// File: rtl/lin_tx_gate.sv
module lin_tx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic normal_i,
  input  logic txd_i,
  input  logic slp_i,
  input  logic uv_i,
  input  logic tsd_i,
  output logic tx_en_o
);
  logic armed_q;

  // block on mode exit or fault, re-arm only on recessive TXD
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (!normal_i || uv_i || tsd_i) armed_q <= 1'b0;
    else if (txd_i) armed_q <= 1'b1;
  end

  assign tx_en_o = normal_i && armed_q && slp_i && !uv_i && !tsd_i;

  a_r8_arm_on_recessive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(txd_i));
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 10,
  parameter int unsigned SLEEP_US     = 6,
  parameter int unsigned NORM_US      = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_ok_i,
  input  logic       slp_n_i,
  input  logic       txd_i,
  input  logic       wake_i,
  input  logic       uv_i,
  input  logic       tsd_i,
  output logic       tx_en_o,
  output logic [1:0] rxd_sel_o,
  output logic [1:0] mode_o
);
  localparam int unsigned SLEEP_TICKS = TICKS_PER_US * SLEEP_US;
  localparam int unsigned NORM_TICKS  = TICKS_PER_US * NORM_US;

  lin_mode_e mode_q, mode_d;
  rxd_sel_e  rxd_sel;
  logic [1:0] pin_s;
  logic slp_s, txd_s;
  logic go_sleep, go_norm, gate_en;

  lin_pin_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({slp_n_i, txd_i}),
    .q_o   (pin_s)
  );
  assign slp_s = pin_s[1];
  assign txd_s = pin_s[0];

  lin_hold_timer #(.LIMIT(SLEEP_TICKS)) u_sleep_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (por_ok_i && mode_q == MODE_NORMAL && !slp_s),
    .fire_o(go_sleep)
  );

  lin_hold_timer #(.LIMIT(NORM_TICKS)) u_norm_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (por_ok_i && (mode_q == MODE_SLEEP || mode_q == MODE_STANDBY) && slp_s),
    .fire_o(go_norm)
  );

  always_comb begin
    mode_d = mode_q;
    if (!por_ok_i) mode_d = MODE_RESET;
    else begin
      unique case (mode_q)
        MODE_RESET:   mode_d = MODE_SLEEP;
        MODE_SLEEP:   if (go_norm) mode_d = MODE_NORMAL;
                      else if (wake_i) mode_d = MODE_STANDBY;
        MODE_STANDBY: if (go_norm) mode_d = MODE_NORMAL;
        MODE_NORMAL:  if (go_sleep) mode_d = MODE_SLEEP;
        default:      mode_d = MODE_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RESET;
    else mode_q <= mode_d;
  end

  lin_tx_gate u_tx_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .normal_i(mode_q == MODE_NORMAL),
    .txd_i   (txd_s),
    .slp_i   (slp_s),
    .uv_i    (uv_i),
    .tsd_i   (tsd_i),
    .tx_en_o (gate_en)
  );

  always_comb begin
    unique case (mode_q)
      MODE_STANDBY: rxd_sel = RXD_LOW;
      MODE_NORMAL:  rxd_sel = RXD_DATA;
      default:      rxd_sel = RXD_FLOAT;
    endcase
  end

  assign tx_en_o   = gate_en && por_ok_i;
  assign rxd_sel_o = rxd_sel;
  assign mode_o    = mode_q;

  a_r1_por_forces_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok_i |=> mode_o == 2'd0);
  a_r2_reset_exits_to_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == MODE_RESET && mode_q != MODE_RESET) |-> mode_q == MODE_SLEEP);
  a_r4_sleep_pin_cuts_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slp_s |-> !tx_en_o);
  a_r6_standby_from_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STANDBY && $past(mode_q) != MODE_STANDBY)
      |-> ($past(mode_q) == MODE_SLEEP && $past(wake_i)));
  a_r9_uv_cuts_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> !tx_en_o);
  a_r10_tsd_cuts_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsd_i |-> !tx_en_o);
endmodule

// File: tb/sim_lin_mode_ctrl.sv
`timescale 1ns/1ps
module sim_lin_mode_ctrl;
  localparam int TPU = 2;
  localparam int SUS = 3;
  localparam int NUS = 2;
  localparam int LS  = TPU * SUS;
  localparam int LN  = TPU * NUS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_ok = 1'b0, slp_n = 1'b0, txd = 1'b0, wake = 1'b0, uv = 1'b0, tsd = 1'b0;
  logic tx_en;
  logic [1:0] rxd_sel, mode;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lin_mode_ctrl #(.TICKS_PER_US(TPU), .SLEEP_US(SUS), .NORM_US(NUS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .por_ok_i(por_ok), .slp_n_i(slp_n), .txd_i(txd),
    .wake_i(wake), .uv_i(uv), .tsd_i(tsd), .tx_en_o(tx_en), .rxd_sel_o(rxd_sel), .mode_o(mode)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic to_normal_from_low_pin();
    slp_n = 1'b1;
    step(LN + 2);
    chk("R7 normal entry", mode, 3);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    slp_n = 1'b1; txd = 1'b1;
    step(2);
    rst_n = 1'b1;
    // R1: supply not good, pins active
    step(3);
    chk("R1 mode", mode, 0);
    chk("R1 rxd", rxd_sel, 0);
    chk("R1 tx", tx_en, 0);
    wake = 1'b1; step(1); wake = 1'b0;
    step(LN + 4);
    chk("R1 ignore inputs", mode, 0);

    // R2
    slp_n = 1'b0; step(3);
    por_ok = 1'b1; step(1);
    chk("R2 sleep", mode, 1);
    chk("R2 rxd float", rxd_sel, 0);

    // R6 wake
    wake = 1'b1; step(1); wake = 1'b0;
    chk("R6 standby", mode, 2);
    chk("R6 rxd low", rxd_sel, 1);
    chk("R6 tx off", tx_en, 0);
    wake = 1'b1; step(1); wake = 1'b0; step(2);
    chk("R6 wake in standby", mode, 2);

    // R7 short high pulses
    for (int p = 1; p < LN; p++) begin
      slp_n = 1'b1; step(p); slp_n = 1'b0; step(LN + 4);
      chk("R7 short pulse", mode, 2);
    end
    // R7/R8 exact edge with TXD low
    txd = 1'b0;
    slp_n = 1'b1;
    step(LN + 1);
    chk("R7 one before", mode, 2);
    step(1);
    chk("R7 at edge", mode, 3);
    chk("R7 rxd data", rxd_sel, 2);
    step(6);
    chk("R8 txd low blocks", tx_en, 0);
    txd = 1'b1;
    step(2);
    chk("R8 before arm", tx_en, 0);
    step(1);
    chk("R8 armed", tx_en, 1);

    wake = 1'b1; step(1); wake = 1'b0; step(1);
    chk("R6 wake in normal", mode, 3);

    // R4
    slp_n = 1'b0; step(1);
    chk("R4 one edge", tx_en, 1);
    step(1);
    chk("R4 cut", tx_en, 0);
    slp_n = 1'b1; step(LS + 4);
    chk("R3 glitch no sleep", mode, 3);

    // R3 short low pulses
    for (int p = 1; p < LS; p++) begin
      slp_n = 1'b0; step(p); slp_n = 1'b1; step(LS + 4);
      chk("R3 short pulse", mode, 3);
    end
    chk("R4 tx back", tx_en, 1);

    // R3/R5 exact edge with faults and TXD low
    txd = 1'b0; uv = 1'b1; tsd = 1'b1;
    slp_n = 1'b0;
    step(LS + 1);
    chk("R5 one before", mode, 3);
    step(1);
    chk("R3 sleep edge", mode, 1);
    chk("R3 rxd float", rxd_sel, 0);
    uv = 1'b0; tsd = 1'b0; txd = 1'b1;

    // R7 from Sleep directly, then R9
    to_normal_from_low_pin();
    step(4);
    chk("R9 start tx", tx_en, 1);
    uv = 1'b1; txd = 1'b0;
    #1;
    chk("R9 immediate off", tx_en, 0);
    step(3);
    chk("R10 uv keeps mode", mode, 3);
    uv = 1'b0; step(5);
    chk("R9 txd low stays off", tx_en, 0);
    txd = 1'b1; step(4);
    chk("R9 rearm", tx_en, 1);

    // R10
    tsd = 1'b1; txd = 1'b0;
    #1;
    chk("R10 immediate off", tx_en, 0);
    step(3);
    chk("R10 mode kept", mode, 3);
    tsd = 1'b0; step(5);
    chk("R10 txd low stays off", tx_en, 0);
    txd = 1'b1; step(4);
    chk("R10 rearm", tx_en, 1);

    // R1 supply loss in Normal
    por_ok = 1'b0; step(1);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset tx", tx_en, 0);
    chk("R1 reset rxd", rxd_sel, 0);
    slp_n = 1'b0; step(LS + 4);
    chk("R1 stays reset", mode, 0);
    por_ok = 1'b1; step(1);
    chk("R2 re-entry", mode, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule